// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block holds one address reservation for a single processor, so that software can build an atomic read-modify-write from a load-linked and a later store-conditional. Interrupts stay enabled. A load-linked opens a reservation on the word it reads. The store-conditional may commit its write only if that reservation is still intact when the store arrives. The block watches for things that can spoil the reservation: writes by other agents, seen on a snoop port, and exceptions taken by the processor. Any of these kills the reservation.

The store-conditional verdict is combinational and is given in the same cycle as the strobe. It is delivered as a write-enable for memory, the gated store data, and a 0/1 value for the destination register. The reservation itself updates on the next clock edge. The block may fail a store that had no real conflict, because it compares at word granularity and resolves every same-cycle collision pessimistically. It never lets a store commit after a conflicting write.

Top module: `rsv_monitor`

## Requirements
- R1: After reset the reservation is invalid and the debug address reads zero.
- R2: A load-linked strobe sets the reservation valid on the next cycle. The stored address is the load address with its byte-offset bits (the low log2(DATA_W/8) bits) forced to zero.
- R3: A store-conditional commits when all of these hold in its cycle: the reservation is valid, the store is to the reserved word, no killing snoop is present and no exception is taken. On commit, the write-enable is 1, the result is 1, and the write data equals the store data.
- R4: A failed store-conditional drives the write-enable to 0, the result to 0 and the write data to 0.
- R5: Every store-conditional, whether it succeeds or fails, leaves the reservation invalid on the next cycle, unless a load-linked arrives in the same cycle.
- R6: A store-conditional fails when no reservation is valid, or when its word differs from the reserved word.
- R7: A snooped write to the reserved word invalidates the reservation on the next cycle. A store-conditional in that same cycle fails.
- R8: A snooped write to any other word leaves the reservation unchanged.
- R9: An exception-taken pulse invalidates the reservation on the next cycle. A store-conditional in that cycle fails, and a load-linked in that cycle does not create a reservation.
- R10: A load-linked that coincides with a snooped write to its own word leaves the reservation invalid.
- R11: A new load-linked replaces any earlier reservation.
- R12: While no store-conditional strobe is present, the write-enable and the result are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_valid_i | input | 1 | Load-linked strobe |
| ll_addr_i | input | ADDR_W | Load-linked byte address |
| sc_valid_i | input | 1 | Store-conditional strobe |
| sc_addr_i | input | ADDR_W | Store-conditional byte address |
| sc_data_i | input | DATA_W | Store-conditional data |
| snp_valid_i | input | 1 | A write by another agent is observed |
| snp_addr_i | input | ADDR_W | Byte address of the observed write |
| exc_taken_i | input | 1 | Exception-taken pulse |
| sc_wr_en_o | output | 1 | Memory write enable for the conditional store |
| sc_wr_data_o | output | DATA_W | Store data when committing, else zero |
| sc_result_o | output | DATA_W | Destination register value: 1 success, 0 failure |
| dbg_resv_valid_o | output | 1 | Reservation valid |
| dbg_resv_addr_o | output | ADDR_W | Word-aligned reserved address |

## Verification
A store-conditional can share a cycle with a snooped write to the reserved word, or with an exception. A load-linked can likewise coincide with a snoop to its own word or with an exception. The bench drives each of these pairs on purpose, both with the snoop on the same word at a different byte offset and with the snoop on a neighbouring word. A random phase then mixes all the strobes over a small set of addresses, so that collisions happen often. A behavioural model tracks the reservation as a word index and judges each cycle: a collision must always end in failure and in no reservation, while a snoop on another word must change nothing.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
    localparam int unsigned ADDR_W_DEF = 32;
    localparam int unsigned DATA_W_DEF = 32;

    // number of byte-select bits below the word index
    function automatic int unsigned offset_bits(input int unsigned data_w);
        return (data_w <= 8) ? 0 : $clog2(data_w / 8);
    endfunction
endpackage

// File: rtl/rsv_word_cmp.sv
module rsv_word_cmp #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFS_W  = 2
) (
    input  logic [ADDR_W-1:0] a_i,
    input  logic [ADDR_W-1:0] b_i,
    output logic              same_word_o
);
    // byte-offset bits never take part in the comparison
    always_comb begin
        same_word_o = (a_i[ADDR_W-1:OFS_W] == b_i[ADDR_W-1:OFS_W]);
    end
endmodule

// File: rtl/rsv_verdict.sv
module rsv_verdict #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              sc_valid_i,
    input  logic              resv_valid_i,
    input  logic              sc_hit_i,
    input  logic              snoop_kill_i,
    input  logic              exc_taken_i,
    input  logic [DATA_W-1:0] sc_data_i,
    output logic              commit_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [DATA_W-1:0] result_o
);
    // any same-cycle hazard forces failure: spurious failure is safe
    always_comb begin
        commit_o  = sc_valid_i & resv_valid_i & sc_hit_i
                  & ~snoop_kill_i & ~exc_taken_i;
        wr_data_o = commit_o ? sc_data_i : '0;
        result_o  = {{(DATA_W-1){1'b0}}, commit_o};
    end
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor #(
    parameter int unsigned ADDR_W = rsv_pkg::ADDR_W_DEF,
    parameter int unsigned DATA_W = rsv_pkg::DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ll_valid_i,
    input  logic [ADDR_W-1:0] ll_addr_i,
    input  logic              sc_valid_i,
    input  logic [ADDR_W-1:0] sc_addr_i,
    input  logic [DATA_W-1:0] sc_data_i,
    input  logic              snp_valid_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    input  logic              exc_taken_i,
    output logic              sc_wr_en_o,
    output logic [DATA_W-1:0] sc_wr_data_o,
    output logic [DATA_W-1:0] sc_result_o,
    output logic              dbg_resv_valid_o,
    output logic [ADDR_W-1:0] dbg_resv_addr_o
);
    localparam int unsigned OFS_W = rsv_pkg::offset_bits(DATA_W);
    localparam logic [ADDR_W-1:0] WORD_MASK = {ADDR_W{1'b1}} << OFS_W;
    localparam int unsigned N_CMP = 3;
    localparam int unsigned CMP_SC    = 0;   // store vs reservation
    localparam int unsigned CMP_SNP   = 1;   // snoop vs reservation
    localparam int unsigned CMP_SNPLL = 2;   // snoop vs new load-linked

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } resv_t;

    resv_t resv_d, resv_q;

    logic [ADDR_W-1:0] cmp_a [N_CMP];
    logic [ADDR_W-1:0] cmp_b [N_CMP];
    logic [N_CMP-1:0]  same_word;

    always_comb begin
        cmp_a[CMP_SC]    = sc_addr_i;
        cmp_b[CMP_SC]    = resv_q.addr;
        cmp_a[CMP_SNP]   = snp_addr_i;
        cmp_b[CMP_SNP]   = resv_q.addr;
        cmp_a[CMP_SNPLL] = snp_addr_i;
        cmp_b[CMP_SNPLL] = ll_addr_i;
    end

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        rsv_word_cmp #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) cmp_i (
            .a_i         (cmp_a[g]),
            .b_i         (cmp_b[g]),
            .same_word_o (same_word[g])
        );
    end

    logic snoop_kill;
    logic snoop_on_ll;
    logic commit;

    always_comb begin
        snoop_kill  = snp_valid_i & resv_q.valid & same_word[CMP_SNP];
        snoop_on_ll = snp_valid_i & same_word[CMP_SNPLL];
    end

    rsv_verdict #(.DATA_W(DATA_W)) verdict_i (
        .sc_valid_i   (sc_valid_i),
        .resv_valid_i (resv_q.valid),
        .sc_hit_i     (same_word[CMP_SC]),
        .snoop_kill_i (snoop_kill),
        .exc_taken_i  (exc_taken_i),
        .sc_data_i    (sc_data_i),
        .commit_o     (commit),
        .wr_data_o    (sc_wr_data_o),
        .result_o     (sc_result_o)
    );

    // next-state: exception beats load-linked, which beats clearing
    always_comb begin
        resv_d = resv_q;
        if (exc_taken_i) begin
            resv_d.valid = 1'b0;
        end else if (ll_valid_i) begin
            resv_d.valid = ~snoop_on_ll;
            resv_d.addr  = ll_addr_i & WORD_MASK;
        end else if (sc_valid_i || snoop_kill) begin
            resv_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resv_q <= '0;
        end else begin
            resv_q <= resv_d;
        end
    end

    assign sc_wr_en_o       = commit;
    assign dbg_resv_valid_o = resv_q.valid;
    assign dbg_resv_addr_o  = resv_q.addr;
endmodule

// File: rtl/rsv_monitor_chk.sv
module rsv_monitor_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ll_valid_i,
    input logic [ADDR_W-1:0] ll_addr_i,
    input logic              sc_valid_i,
    input logic [ADDR_W-1:0] sc_addr_i,
    input logic [DATA_W-1:0] sc_data_i,
    input logic              snp_valid_i,
    input logic [ADDR_W-1:0] snp_addr_i,
    input logic              exc_taken_i,
    input logic              sc_wr_en_o,
    input logic [DATA_W-1:0] sc_wr_data_o,
    input logic [DATA_W-1:0] sc_result_o,
    input logic              dbg_resv_valid_o,
    input logic [ADDR_W-1:0] dbg_resv_addr_o
);
    localparam int unsigned OFS_W = rsv_pkg::offset_bits(DATA_W);

    logic snp_on_resv, sc_on_resv, snp_on_ll;
    assign snp_on_resv = (snp_addr_i >> OFS_W) == (dbg_resv_addr_o >> OFS_W);
    assign sc_on_resv  = (sc_addr_i  >> OFS_W) == (dbg_resv_addr_o >> OFS_W);
    assign snp_on_ll   = (snp_addr_i >> OFS_W) == (ll_addr_i >> OFS_W);

    a_r12_quiet_without_sc: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_valid_i |-> (!sc_wr_en_o && sc_result_o == '0));

    a_r6_commit_needs_resv: assert property (@(posedge clk) disable iff (!rst_n)
        sc_wr_en_o |-> (dbg_resv_valid_o && sc_on_resv));

    a_r7_snoop_blocks_sc: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid_i && dbg_resv_valid_o && snp_on_resv) |-> !sc_wr_en_o);

    a_r9_exc_blocks_sc: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken_i |-> !sc_wr_en_o);

    a_r9_exc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken_i |=> !dbg_resv_valid_o);

    a_r5_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid_i && !ll_valid_i) |=> !dbg_resv_valid_o);

    a_r4_result_tracks_enable: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid_i |-> (sc_result_o == {{(DATA_W-1){1'b0}}, sc_wr_en_o}));

    a_r10_ll_snoop_no_resv: assert property (@(posedge clk) disable iff (!rst_n)
        (ll_valid_i && snp_valid_i && snp_on_ll) |=> !dbg_resv_valid_o);

    a_r2_ll_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ll_valid_i && !exc_taken_i && !(snp_valid_i && snp_on_ll)) |=>
        (dbg_resv_valid_o &&
         dbg_resv_addr_o == (($past(ll_addr_i) >> OFS_W) << OFS_W)));
endmodule

bind rsv_monitor rsv_monitor_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/rsv_monitor_tb_top.sv
`timescale 1ns/1ps
module rsv_monitor_tb_top;
    localparam int unsigned AW  = 32;
    localparam int unsigned DW  = 32;
    localparam int unsigned OFS = rsv_pkg::offset_bits(DW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ll_v = 1'b0, sc_v = 1'b0, snp_v = 1'b0, exc = 1'b0;
    logic [AW-1:0] ll_a = '0, sc_a = '0, snp_a = '0;
    logic [DW-1:0] sc_d = '0;
    logic          wr_en, r_valid;
    logic [DW-1:0] wr_data, result;
    logic [AW-1:0] r_addr;

    always #2 clk = ~clk;

    rsv_monitor #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ll_valid_i(ll_v), .ll_addr_i(ll_a),
        .sc_valid_i(sc_v), .sc_addr_i(sc_a), .sc_data_i(sc_d),
        .snp_valid_i(snp_v), .snp_addr_i(snp_a), .exc_taken_i(exc),
        .sc_wr_en_o(wr_en), .sc_wr_data_o(wr_data), .sc_result_o(result),
        .dbg_resv_valid_o(r_valid), .dbg_resv_addr_o(r_addr)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // behavioural reference: a flag and a word number
    bit      m_held = 1'b0;
    longint  m_word = 0;

    function automatic longint word_of(input logic [AW-1:0] a);
        return longint'(a) / (longint'(1) << OFS);
    endfunction

    task automatic check(input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // one cycle: apply strobes, judge outputs, advance the model
    task automatic step(input string tag,
                        input bit l, input logic [AW-1:0] la,
                        input bit s, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                        input bit n, input logic [AW-1:0] na,
                        input bit e);
        bit kill, ok;
        ll_v = l; ll_a = la; sc_v = s; sc_a = sa; sc_d = sd;
        snp_v = n; snp_a = na; exc = e;
        #1;
        kill = n && m_held && word_of(na) == m_word;
        ok   = s && m_held && word_of(sa) == m_word && !kill && !e;
        check(tag, "wr_en",   wr_en,   ok);
        check(tag, "result",  result,  ok ? 1 : 0);
        check(tag, "wr_data", wr_data, ok ? longint'(sd) : 0);
        check(tag, "resv_valid", r_valid, m_held);
        if (m_held) check(tag, "resv_addr", r_addr, m_word << OFS);
        if (e) m_held = 1'b0;
        else if (l) begin
            m_word = word_of(la);
            m_held = !(n && word_of(na) == word_of(la));
        end else if (s || kill) m_held = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, '0, 0, '0, '0, 0, '0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "resv_valid", r_valid, 0);
        check("R1", "resv_addr", r_addr, 0);
        rst_n = 1'b1;
        idle("R12");

        // R2 aligned and unaligned load-linked
        step("R2", 1, 32'h100, 0, '0, '0, 0, '0, 0);
        idle("R2");
        step("R2", 1, 32'h10B, 0, '0, '0, 0, '0, 0);
        idle("R2");
        check("R2", "aligned addr", r_addr, 32'h108);
        // R3 success at another byte in the same word, then R5 cleared
        step("R3", 0, '0, 1, 32'h10A, 32'hCAFE_0001, 0, '0, 0);
        idle("R5");
        check("R5", "cleared after success", r_valid, 0);
        // R6 no reservation
        step("R6", 0, '0, 1, 32'h108, 32'h1234, 0, '0, 0);
        // R6 wrong word, R4 failure values, R5 clear after failure
        step("R6", 1, 32'h200, 0, '0, '0, 0, '0, 0);
        step("R4", 0, '0, 1, 32'h300, 32'h5555, 0, '0, 0);
        idle("R5");
        check("R5", "cleared after failure", r_valid, 0);
        // R8 snoop elsewhere is harmless
        step("R8", 1, 32'h200, 0, '0, '0, 0, '0, 0);
        step("R8", 0, '0, 0, '0, '0, 1, 32'h204, 0);
        step("R8", 0, '0, 1, 32'h200, 32'hAAAA, 1, 32'h1FC, 0);
        // R7 snoop kills, then same-cycle snoop plus store
        step("R7", 1, 32'h200, 0, '0, '0, 0, '0, 0);
        step("R7", 0, '0, 0, '0, '0, 1, 32'h202, 0);
        step("R7", 0, '0, 1, 32'h200, 32'h7, 0, '0, 0);
        step("R7", 1, 32'h200, 0, '0, '0, 0, '0, 0);
        step("R7", 0, '0, 1, 32'h200, 32'h8, 1, 32'h201, 0);
        // R9 exception alone, with store, with load-linked
        step("R9", 1, 32'h200, 0, '0, '0, 0, '0, 0);
        step("R9", 0, '0, 0, '0, '0, 0, '0, 1);
        step("R9", 0, '0, 1, 32'h200, 32'h9, 0, '0, 0);
        step("R9", 1, 32'h200, 0, '0, '0, 0, '0, 0);
        step("R9", 0, '0, 1, 32'h200, 32'h9, 0, '0, 1);
        step("R9", 1, 32'h240, 0, '0, '0, 0, '0, 1);
        idle("R9");
        // R10 load-linked racing a snoop to its own word
        step("R10", 1, 32'h300, 0, '0, '0, 1, 32'h303, 0);
        idle("R10");
        check("R10", "no reservation", r_valid, 0);
        // R11 second load-linked replaces the first
        step("R11", 1, 32'h200, 0, '0, '0, 0, '0, 0);
        step("R11", 1, 32'h400, 0, '0, '0, 0, '0, 0);
        step("R11", 0, '0, 1, 32'h200, 32'hB, 0, '0, 0);
        step("R11", 1, 32'h400, 0, '0, '0, 0, '0, 0);
        step("R11", 0, '0, 1, 32'h400, 32'hC, 0, '0, 0);

        // mixed traffic over four words
        for (int i = 0; i < 2000; i++) begin
            logic [AW-1:0] la, sa, na;
            la = AW'((($urandom % 4) << OFS) | ($urandom % 4) | 32'h800);
            sa = AW'((($urandom % 4) << OFS) | ($urandom % 4) | 32'h800);
            na = AW'((($urandom % 4) << OFS) | ($urandom % 4) | 32'h800);
            step("R3/R7/R9 mix", ($urandom % 3) == 0, la, ($urandom % 3) == 0, sa,
                 DW'($urandom), ($urandom % 4) == 0, na, ($urandom % 10) == 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule